// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of an 8-bit successive approximation converter. When a start request is accepted, it performs a binary search. It drives a trial code to an external DAC or tap selector and reads back a single comparator bit that tells whether the analog input lies at or above the trial level. The search starts with the most significant bit. It takes one bit slot of a fixed number of clocks per bit, so a whole conversion lasts a fixed number of clocks.

When the last bit is decided, the result is stored in an output latch in complementary binary form, and end of conversion is raised. The latch is written only when a conversion completes. Valid data from the previous conversion therefore stays on the data outputs while the next conversion runs.

The comparator bit passes through a synchronizer before it is used. The data outputs come with a pad drive enable that follows output enable. Tying start to end of conversion makes the block convert continuously, but the first conversion after reset still needs an external start pulse.

Top module: `sar_conv_ctrl`

## Requirements
- R1: On the clock edge that accepts start (start_i high at a rising edge), trial_o becomes 8'h80, with only the most significant bit set.
- R2: Each bit owns a slot of 5 clocks, decided in order from bit 7 down to bit 0. At the slot's last edge the bit under test is kept if the synchronized comparator is 1 and cleared if it is 0, and the next lower bit is set for its trial. After the first slot, trial_o is 8'hC0 for an input at or above mid-scale and 8'h40 otherwise.
- R3: eoc_o rises exactly 40 clock edges after the edge that accepted start.
- R4: At completion the latch receives the bitwise complement of the search result. A full-scale result (8'hFF) reads 8'h00 and a zero result reads 8'hFF.
- R5: The latch value seen on data_o does not change at any time other than a completing edge, including throughout a running conversion.
- R6: data_oe_o equals oe_i. When oe_i is 1, data_o shows the latch. When it is 0, data_o is 8'h00 and the pad is released. oe_i has no effect on the conversion result.
- R7: With start_i tied to eoc_o, conversions repeat back to back with a period of 41 clocks, and eoc_o is high for one clock between them.
- R8: Reset gives eoc_o = 0, trial_o = 8'h00 and a latch value of 8'hFF. Without a start pulse no conversion begins, even when start_i is tied to eoc_o.
- R9: eoc_o is 0 on the clock after a start is accepted and stays 0 until the latch is loaded.
- R10: A start accepted during a conversion aborts it and restarts from the 8'h80 trial. The latch is left untouched, and end of conversion follows 40 clocks after the new start.
- R11: The comparator passes through a two-flop synchronizer. A bit decision at slot edge k uses the comparator level present during the clock that ends two edges before edge k. Levels present only in the last two clocks of a slot have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled on each rising edge |
| cmp_i | input | 1 | Comparator: 1 when the analog input is at or above the trial level |
| oe_i | input | 1 | Output enable for the data pads |
| trial_o | output | 8 | Trial code driven to the DAC or tap selector |
| eoc_o | output | 1 | End of conversion |
| data_o | output | 8 | Latched result in complementary binary, zero while disabled |
| data_oe_o | output | 1 | Pad drive enable; low means high impedance |

## Verification
The search is exercised with an ideal comparator against input codes at zero, full scale, both sides of mid-scale, and single-bit and alternating patterns. This separates a correct bit order, the keep/clear choice and the complementing of the result from near misses such as a reversed bit order or an off-by-one threshold.

A comparator that is high only in chosen clocks of each slot pins down the exact sampling instant behind the synchronizer. Directed runs then cover a start arriving mid-conversion, free running with start tied to end of conversion, disabled output, and the idle state after reset.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned SAR_MAX_W = 32;

  // Decide the bit under test from the comparator and arm the next lower bit.
  function automatic logic [SAR_MAX_W-1:0] sar_refine(
    input logic [SAR_MAX_W-1:0] code,
    input int unsigned          idx,
    input logic                 keep
  );
    logic [SAR_MAX_W-1:0] res;
    res = code;
    if (!keep) res[idx] = 1'b0;
    if (idx > 0) res[idx-1] = 1'b1;
    return res;
  endfunction

  // Code word placed in the output latch (complementary binary).
  function automatic logic [SAR_MAX_W-1:0] sar_out_word(input logic [SAR_MAX_W-1:0] code);
    return ~code;
  endfunction
endpackage

// File: rtl/sar_cmp_sync.sv
module sar_cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int unsigned W         = 8,
  parameter int unsigned SLOT_CLKS = 5,
  localparam int unsigned IDX_W    = (W > 1) ? $clog2(W) : 1,
  localparam int unsigned CNT_W    = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             decide_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CLKS - 1);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(W - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  assign decide_o = busy_q && (cnt_q == CNT_LAST) && !start_i;
  assign last_o   = decide_o && (idx_q == '0);
  assign busy_o   = busy_q;
  assign idx_o    = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      idx_q  <= IDX_TOP;
    end else if (busy_q) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        if (idx_q == '0) busy_q <= 1'b0;
        else idx_q <= idx_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: slot counter never leaves its range while a conversion runs
  a_r2_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= CNT_LAST));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int unsigned W = 8,
  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             decide_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             cmp_s_i,
  output logic [W-1:0]     trial_o,
  output logic [W-1:0]     next_code_o
);
  import sar_pkg::*;

  localparam logic [W-1:0] MSB_TRIAL = W'(1) << (W - 1);

  logic [W-1:0]         trial_q;
  logic [SAR_MAX_W-1:0] refined;

  always_comb begin
    refined     = sar_refine(SAR_MAX_W'(trial_q), int'(idx_i), cmp_s_i);
    next_code_o = refined[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trial_q <= '0;
    else if (start_i) trial_q <= MSB_TRIAL;
    else if (decide_i) trial_q <= next_code_o;
  end

  assign trial_o = trial_q;

  // R2: a low comparator at a decision clears the bit under test
  a_r2_clear_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_i && !cmp_s_i) |=> !trial_q[$past(idx_i)]);
  // R2: a high comparator at a decision keeps the bit under test
  a_r2_keep_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_i && cmp_s_i) |=> trial_q[$past(idx_i)]);
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int unsigned W           = 8,
  parameter int unsigned SLOT_CLKS   = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         cmp_i,
  input  logic         oe_i,
  output logic [W-1:0] trial_o,
  output logic         eoc_o,
  output logic [W-1:0] data_o,
  output logic         data_oe_o
);
  import sar_pkg::*;

  localparam int unsigned CONV_CLKS = W * SLOT_CLKS;
  localparam int unsigned IDX_W     = (W > 1) ? $clog2(W) : 1;
  localparam int unsigned SS_W      = $clog2(CONV_CLKS + 2) + 1;

  logic             cmp_s;
  logic             busy_w;
  logic [IDX_W-1:0] idx_w;
  logic             decide_w;
  logic             load_w;
  logic [W-1:0]     next_code_w;
  logic [W-1:0]     latch_q;
  logic             eoc_q;
  logic [SAR_MAX_W-1:0] out_word;

  sar_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cmp_i), .q_o(cmp_s)
  );

  sar_sequencer #(.W(W), .SLOT_CLKS(SLOT_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy_w), .idx_o(idx_w), .decide_o(decide_w), .last_o(load_w)
  );

  sar_trial_reg #(.W(W)) u_trial (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .decide_i(decide_w),
    .idx_i(idx_w), .cmp_s_i(cmp_s), .trial_o(trial_o), .next_code_o(next_code_w)
  );

  always_comb out_word = sar_out_word(SAR_MAX_W'(next_code_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      eoc_q   <= 1'b0;
    end else if (start_i) begin
      eoc_q   <= 1'b0;
    end else if (load_w) begin
      latch_q <= out_word[W-1:0];
      eoc_q   <= 1'b1;
    end
  end

  assign eoc_o     = eoc_q;
  assign data_oe_o = oe_i;
  assign data_o    = oe_i ? latch_q : '0;

  // Cycles since the last accepted start, kept for the length check.
  logic [SS_W-1:0] since_start_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_start_q <= '0;
    else if (start_i) since_start_q <= '0;
    else if (busy_w) since_start_q <= since_start_q + 1'b1;
  end

  a_r1_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (trial_o == (W'(1) << (W - 1))));
  a_r3_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_q) |-> (since_start_q == SS_W'(CONV_CLKS)));
  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_w |=> $stable(latch_q));
  a_r9_eoc_drops: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !eoc_q);
  a_r10_abort_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_w) |=> $stable(latch_q));
endmodule

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb_top;
  localparam int W = 8;
  localparam int NVEC = 8;
  localparam logic [7:0] VIN_TAB [NVEC] =
    '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'hA5, 8'h5A, 8'hFE};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_pulse = 1'b0;
  logic free_mode = 1'b0;
  logic oe = 1'b1;
  logic man_mode = 1'b0;
  logic cmp_man = 1'b0;
  logic [7:0] vin = 8'h00;
  logic start_i, cmp_i;
  logic [W-1:0] trial_o, data_o;
  logic eoc_o, data_oe_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] prev_data = 8'hFF;

  always #10 clk = ~clk;

  assign start_i = free_mode ? (eoc_o | start_pulse) : start_pulse;
  assign cmp_i   = man_mode ? cmp_man : (vin >= trial_o);

  sar_conv_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i), .oe_i(oe),
    .trial_o(trial_o), .eoc_o(eoc_o), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Pulse start; returns at the negedge just after the accepting edge.
  task automatic kick();
    @(negedge clk) start_pulse = 1'b1;
    @(negedge clk) start_pulse = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R8: reset state
    chk(eoc_o == 1'b0, "R8 eoc reset", eoc_o, 0);
    chk(trial_o == 8'h00, "R8 trial reset", trial_o, 0);
    chk(data_o == 8'hFF, "R8 latch reset", data_o, 8'hFF);
    rst_n = 1'b1;
    free_mode = 1'b1;
    tick(60);
    chk(eoc_o == 1'b0, "R8 no self start", eoc_o, 0);
    chk(trial_o == 8'h00, "R8 idle trial", trial_o, 0);
    free_mode = 1'b0;

    // Vector table: ideal comparator against each input code
    for (int v = 0; v < NVEC; v++) begin
      vin = VIN_TAB[v];
      kick();
      chk(trial_o == 8'h80, "R1 msb trial", trial_o, 8'h80);
      chk(eoc_o == 1'b0, "R9 eoc low after start", eoc_o, 0);
      chk(data_o == prev_data, "R5 latch held at start", data_o, prev_data);
      tick(5);
      chk(trial_o == ((vin >= 8'h80 ? 8'h80 : 8'h00) | 8'h40), "R2 first slot",
          trial_o, (vin >= 8'h80 ? 8'h80 : 8'h00) | 8'h40);
      tick(15);
      chk(data_o == prev_data, "R5 latch held mid", data_o, prev_data);
      tick(19);
      chk(eoc_o == 1'b0, "R3 eoc not early", eoc_o, 0);
      tick(1);
      chk(eoc_o == 1'b1, "R3 eoc at 40", eoc_o, 1);
      chk(data_o == ~vin, "R4 complement result", data_o, ~vin);
      prev_data = ~vin;
    end

    // R11: comparator high only in the clock ending two edges before each decision
    man_mode = 1'b1;
    kick();
    for (int j = 0; j < 40; j++) begin
      cmp_man = (((j + 1) % 5) == 3);
      tick(1);
    end
    chk(eoc_o == 1'b1, "R11 eoc", eoc_o, 1);
    chk(data_o == 8'h00, "R11 sampled clock", data_o, 8'h00);
    // R11: comparator high only in the last two clocks of each slot
    kick();
    for (int j = 0; j < 40; j++) begin
      cmp_man = (((j + 1) % 5) == 4) || (((j + 1) % 5) == 0);
      tick(1);
    end
    chk(data_o == 8'hFF, "R11 late levels ignored", data_o, 8'hFF);
    cmp_man = 1'b0;
    man_mode = 1'b0;
    prev_data = 8'hFF;

    // R10: abort and restart
    vin = 8'h33;
    kick();
    tick(12);
    kick();
    chk(trial_o == 8'h80, "R10 restart msb", trial_o, 8'h80);
    chk(data_o == prev_data, "R10 latch untouched", data_o, prev_data);
    tick(39);
    chk(eoc_o == 1'b0, "R10 old conversion gone", eoc_o, 0);
    tick(1);
    chk(eoc_o == 1'b1 && data_o == 8'hCC, "R10 new result", data_o, 8'hCC);

    // R6: output enable gates pads only
    vin = 8'h6E;
    kick();
    oe = 1'b0;
    tick(2);
    chk(data_oe_o == 1'b0, "R6 pad released", data_oe_o, 0);
    chk(data_o == 8'h00, "R6 data off", data_o, 0);
    tick(38);
    oe = 1'b1;
    #1;
    chk(data_oe_o == 1'b1 && data_o == 8'h91, "R6 result unaffected", data_o, 8'h91);

    // R7: free running
    vin = 8'h12;
    free_mode = 1'b1;
    kick();
    tick(39);
    chk(eoc_o == 1'b0, "R7 first not done", eoc_o, 0);
    tick(1);
    chk(eoc_o == 1'b1 && data_o == 8'hED, "R7 first result", data_o, 8'hED);
    vin = 8'h34;
    tick(1);
    chk(eoc_o == 1'b0, "R7 auto restart", eoc_o, 0);
    tick(39);
    chk(eoc_o == 1'b0, "R7 second not early", eoc_o, 0);
    tick(1);
    chk(eoc_o == 1'b1 && data_o == 8'hCB, "R7 second result", data_o, 8'hCB);
    free_mode = 1'b0;
    tick(20);
    chk(eoc_o == 1'b1, "R7 stops when untied", eoc_o, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule